// File: doc/BRIEF.md
# Parallel Route-Lookup Dispatcher

This block takes a stream of 32-bit IPv4 destination addresses and spreads them across a small pool of longest-prefix lookup engines. All engines share one pipelined external SRAM port. A run-time register chooses how many of the engines may accept new work. Each accepted address gets a 3-bit sequence tag. A reorder buffer hands results out strictly in acceptance order, even though short lookups overtake long ones. The SRAM has a fixed read latency of two cycles.

Each engine is a deterministic requester. It makes `addr[1:0]+1` chained reads through a table, and the last word read supplies the next hop. Route-table update writes from a control processor use the same memory port. They win arbitration over lookup reads, but a starvation counter bounds how long reads can be held off. The engine pool size, the read-starvation bound and the memory widths are all set by parameters in the shared package.

Top module: `lkpDispatch`

## Requirements
- R1: After reset, inReady is 1, resValid is 0 and memReq is 0, and all ENG_N (default 4) engines are enabled.
- R2: A new address goes to the next idle enabled engine in round-robin order. inReady is 0 whenever no enabled engine is idle. With N engines enabled and all lookups long, exactly N addresses are taken back to back before inReady falls.
- R3: A lookup on address A makes `A[1:0]+1` reads. Read k goes to memory address `{k[1:0], p_k}`. Here p_0 is A[31:24], and p_(k+1) is `data_k[7:0]` XOR byte (2-k) of A, where byte 2 is A[23:16], byte 1 is A[15:8] and byte 0 is A[7:0]. The next hop is bits [15:8] of the last word read. Read data for a request in cycle c is taken from memRdata in cycle c+2.
- R4: A write with cfgWe loads the enabled-engine count from cfgCount. A value of 0 is treated as 1, and any value above ENG_N is treated as ENG_N.
- R5: At most one memory access is made per cycle. When updValid is high and reads are not being starved, the write goes out in that same cycle: memReq=1, memWe=1, and memAddr/memWdata equal updAddr/updData. updReady marks the cycle the write is taken.
- R6: While any engine has a read pending, the port serves a read at least once in every STARVE_MAX+1 cycles, even with updValid held high.
- R7: Results leave in acceptance order. resTag is the acceptance count modulo 8, and each result appears as a one-cycle resValid pulse.
- R8: Lowering the enabled count stops new assignments to the disabled engines. Lookups already running on those engines still finish and deliver their results.
- R9: A completed update write is seen by every lookup accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Address offered |
| inAddr | input | 32 | IPv4 destination address |
| inReady | output | 1 | An enabled engine is idle and a reorder slot is free |
| cfgWe | input | 1 | Write strobe for the engine count |
| cfgCount | input | 4 | Requested number of enabled engines |
| updValid | input | 1 | Update write pending |
| updAddr | input | 10 | Update write address |
| updData | input | 16 | Update write data |
| updReady | output | 1 | Update write issued this cycle |
| memReq | output | 1 | SRAM access strobe |
| memWe | output | 1 | SRAM write enable |
| memAddr | output | 10 | SRAM address |
| memWdata | output | 16 | SRAM write data |
| memRdata | input | 16 | SRAM read data, two cycles after the request |
| resValid | output | 1 | Result valid |
| resTag | output | 3 | Sequence tag of the result |
| resNextHop | output | 8 | Next hop |

## Verification
Some properties are checked by assertions on every cycle:
- every read return lands on a busy engine that is waiting for data;
- the memory port never carries a write and a read grant together;
- assignments go only to idle, enabled engines;
- no pending read waits more than STARVE_MAX cycles.

Other behaviour can only be shown by the bench scenarios. These cover the exact next-hop values and the in-order release after out-of-order completion. They also cover the burst length that follows each count write, including the clamped counts, and the completion of lookups stranded on engines that were just disabled. Finally, they show that an update write is seen by a later lookup.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  localparam int ENG_N   = 4;
  localparam int ROB_N   = 8;
  localparam int TAG_W   = $clog2(ROB_N);
  localparam int STEP_W  = 2;
  localparam int PTR_W   = 8;
  localparam int MEM_AW  = STEP_W + PTR_W;
  localparam int DATA_W  = 16;
  localparam int NH_W    = 8;
  localparam int CNT_W   = 4;

  typedef struct packed {
    logic [ENG_N-1:0]  load;
    logic [ENG_N-1:0]  issue;
    logic [ENG_N-1:0]  fill;
    logic              lastFill;
    logic [STEP_W-1:0] issueStep;
    logic [STEP_W-1:0] fillStep;
    logic [TAG_W-1:0]  loadTag;
    logic [TAG_W-1:0]  headTag;
    logic              pop;
  } strobe_t;
endpackage

// File: rtl/lkpDatapath.sv
module lkpDatapath
  import lkp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [31:0]       inAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [MEM_AW-1:0] readAddr,
  output logic [TAG_W-1:0]  fillTag,
  output logic [NH_W-1:0]   resNextHop,
  output logic [TAG_W-1:0]  resTag
);
  logic [23:0]      destLow [ENG_N];
  logic [PTR_W-1:0] ptr     [ENG_N];
  logic [TAG_W-1:0] tagE    [ENG_N];
  logic [NH_W-1:0]  rob     [ROB_N];

  function automatic logic [7:0] pickByte(input logic [23:0] d, input logic [STEP_W-1:0] s);
    case (s)
      2'd0:    pickByte = d[23:16];
      2'd1:    pickByte = d[15:8];
      default: pickByte = d[7:0];
    endcase
  endfunction

  for (genvar e = 0; e < ENG_N; e++) begin : g_eng
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        destLow[e] <= '0;
        ptr[e]     <= '0;
        tagE[e]    <= '0;
      end else if (strb.load[e]) begin
        destLow[e] <= inAddr[23:0];
        ptr[e]     <= inAddr[31:24];
        tagE[e]    <= strb.loadTag;
      end else if (strb.fill[e] && !strb.lastFill) begin
        ptr[e] <= memRdata[7:0] ^ pickByte(destLow[e], strb.fillStep);
      end
    end
  end

  always_comb begin
    readAddr = '0;
    fillTag  = '0;
    for (int e = 0; e < ENG_N; e++) begin
      if (strb.issue[e]) readAddr = {strb.issueStep, ptr[e]};
      if (strb.fill[e])  fillTag  = tagE[e];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.lastFill) rob[fillTag] <= memRdata[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resNextHop <= '0;
      resTag     <= '0;
    end else if (strb.pop) begin
      resNextHop <= rob[strb.headTag];
      resTag     <= strb.headTag;
    end
  end
endmodule

// File: rtl/lkpControl.sv
module lkpControl
  import lkp_pkg::*;
#(
  parameter int STARVE_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [1:0]       inLow,
  input  logic             cfgWe,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             updValid,
  input  logic [TAG_W-1:0] fillTag,
  output logic             inReady,
  output logic             updGrant,
  output logic             readWin,
  output logic             resValid,
  output strobe_t          strb
);
  localparam int SW  = $clog2(STARVE_MAX + 1);
  localparam int EW  = $clog2(ENG_N);
  localparam int RCW = $clog2(ROB_N + 1);

  logic [ENG_N-1:0]  busy, needReq, idleEn, reqVec;
  logic [STEP_W-1:0] step [ENG_N];
  logic [STEP_W-1:0] lastStep [ENG_N];
  logic [CNT_W-1:0]  activeCnt;
  logic [EW-1:0]     rrLoad, rrIss, loadEng, issEng;
  logic              loadOk, issOk, fire, lastOfFill;
  logic [TAG_W-1:0]  tailTag, headTag;
  logic [RCW-1:0]    robCnt;
  logic [ROB_N-1:0]  robValid;
  logic [SW-1:0]     starveCnt;
  logic              v0, v1;
  logic [EW-1:0]     e0, e1;
  logic [STEP_W-1:0] s0, s1, issStep;

  always_comb begin
    for (int e = 0; e < ENG_N; e++) begin
      idleEn[e] = !busy[e] && (CNT_W'(e) < activeCnt);
      reqVec[e] = busy[e] && needReq[e];
    end
    loadOk = 1'b0; loadEng = '0; issOk = 1'b0; issEng = '0;
    for (int i = 0; i < ENG_N; i++) begin
      int li, ri;
      li = (int'(rrLoad) + i) % ENG_N;
      ri = (int'(rrIss) + i) % ENG_N;
      if (!loadOk && idleEn[li]) begin loadOk = 1'b1; loadEng = EW'(li); end
      if (!issOk && reqVec[ri])  begin issOk  = 1'b1; issEng  = EW'(ri); end
    end
    issStep = '0; lastOfFill = 1'b0;
    for (int e = 0; e < ENG_N; e++) begin
      if (issEng == EW'(e)) issStep = step[e];
      if (e1 == EW'(e))     lastOfFill = (s1 == lastStep[e]);
    end
  end

  assign inReady  = loadOk && (robCnt < RCW'(ROB_N));
  assign fire     = inValid && inReady;
  assign readWin  = issOk && (!updValid || starveCnt == SW'(STARVE_MAX));
  assign updGrant = updValid && !readWin;

  always_comb begin
    strb           = '0;
    strb.load      = fire    ? (ENG_N'(1) << loadEng) : '0;
    strb.issue     = readWin ? (ENG_N'(1) << issEng)  : '0;
    strb.fill      = v1      ? (ENG_N'(1) << e1)      : '0;
    strb.lastFill  = v1 && lastOfFill;
    strb.issueStep = issStep;
    strb.fillStep  = s1;
    strb.loadTag   = tailTag;
    strb.headTag   = headTag;
    strb.pop       = robValid[headTag];
  end

  for (genvar e = 0; e < ENG_N; e++) begin : g_eng
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[e] <= 1'b0; needReq[e] <= 1'b0; step[e] <= '0; lastStep[e] <= '0;
      end else if (strb.load[e]) begin
        busy[e] <= 1'b1; needReq[e] <= 1'b1; step[e] <= '0; lastStep[e] <= inLow;
      end else if (strb.issue[e]) begin
        needReq[e] <= 1'b0;
      end else if (strb.fill[e]) begin
        if (strb.lastFill) busy[e] <= 1'b0;
        else begin step[e] <= step[e] + 1'b1; needReq[e] <= 1'b1; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeCnt <= CNT_W'(ENG_N);
      rrLoad <= '0; rrIss <= '0; tailTag <= '0; headTag <= '0;
      robCnt <= '0; robValid <= '0; starveCnt <= '0;
      v0 <= 1'b0; v1 <= 1'b0; e0 <= '0; e1 <= '0; s0 <= '0; s1 <= '0;
      resValid <= 1'b0;
    end else begin
      if (cfgWe)
        activeCnt <= (cfgCount == '0) ? CNT_W'(1) :
                     (cfgCount > CNT_W'(ENG_N)) ? CNT_W'(ENG_N) : cfgCount;
      if (fire) begin
        rrLoad  <= EW'((int'(loadEng) + 1) % ENG_N);
        tailTag <= tailTag + 1'b1;
      end
      if (readWin) rrIss <= EW'((int'(issEng) + 1) % ENG_N);
      if (strb.pop) begin
        robValid[headTag] <= 1'b0;
        headTag <= headTag + 1'b1;
      end
      if (strb.lastFill) robValid[fillTag] <= 1'b1;
      robCnt <= robCnt + RCW'(fire) - RCW'(strb.pop);
      if (!issOk || readWin) starveCnt <= '0;
      else if (updGrant)     starveCnt <= starveCnt + 1'b1;
      v0 <= readWin; e0 <= issEng; s0 <= issStep;
      v1 <= v0;      e1 <= e0;     s1 <= s0;
      resValid <= strb.pop;
    end
  end

  // Independent run-length counter of unserved pending reads
  logic [7:0] holdRun;
  always_ff @(posedge clk) begin
    if (!rst_n) holdRun <= '0;
    else if (|reqVec && !readWin) holdRun <= holdRun + 1'b1;
    else holdRun <= '0;
  end

  p_starve_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(holdRun) <= STARVE_MAX);
  p_fill_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> |(busy & ~needReq & strb.fill));
  p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({updGrant, strb.issue}));
  p_load_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (CNT_W'(loadEng) < activeCnt) && !(|(busy & strb.load)));
  p_rob_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.pop |-> robCnt != '0);
endmodule

// File: rtl/lkpDispatch.sv
module lkpDispatch
  import lkp_pkg::*;
#(
  parameter int STARVE_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [31:0]       inAddr,
  output logic              inReady,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              updValid,
  input  logic [MEM_AW-1:0] updAddr,
  input  logic [DATA_W-1:0] updData,
  output logic              updReady,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [NH_W-1:0]   resNextHop
);
  strobe_t           strb;
  logic              updGrant, readWin;
  logic [MEM_AW-1:0] readAddr;
  logic [TAG_W-1:0]  fillTag;

  lkpControl #(.STARVE_MAX(STARVE_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLow(inAddr[1:0]),
    .cfgWe(cfgWe), .cfgCount(cfgCount), .updValid(updValid), .fillTag(fillTag),
    .inReady(inReady), .updGrant(updGrant), .readWin(readWin),
    .resValid(resValid), .strb(strb)
  );

  lkpDatapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .inAddr(inAddr), .memRdata(memRdata),
    .readAddr(readAddr), .fillTag(fillTag), .resNextHop(resNextHop), .resTag(resTag)
  );

  assign updReady = updGrant;
  assign memReq   = updGrant || readWin;
  assign memWe    = updGrant;
  assign memAddr  = updGrant ? updAddr : readAddr;
  assign memWdata = updData;
endmodule

// File: tb/lkpDispatch_test.sv
`timescale 1ns/1ps
module lkpDispatch_test;
  logic clk = 0, rst_n = 0;
  logic inValid = 0, cfgWe = 0, updValid = 0;
  logic [31:0] inAddr = 0;
  logic [3:0]  cfgCount = 0;
  logic [9:0]  updAddr = 0;
  logic [15:0] updData = 0;
  logic inReady, updReady, memReq, memWe, resValid;
  logic [9:0]  memAddr;
  logic [15:0] memWdata, memRdata, rd1, rd2;
  logic [2:0]  resTag;
  logic [7:0]  resNextHop, lastNh;
  int checks = 0, errors = 0, cycles = 0, seq = 0, sawWait = 0;
  logic [15:0] wmem [int];
  int expTag[$];
  int expNh[$];

  lkpDispatch uut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] initWord(input int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction
  function automatic logic [15:0] memRd(input int a);
    return wmem.exists(a) ? wmem[a] : initWord(a);
  endfunction
  // Reference lookup per R3
  function automatic int refLookup(input logic [31:0] a);
    logic [7:0] p; logic [15:0] d; int n;
    p = a[31:24]; n = int'(a[1:0]) + 1; d = '0;
    for (int k = 0; k < n; k++) begin
      d = memRd({k[1:0], p});
      if (k == 0) p = d[7:0] ^ a[23:16];
      else if (k == 1) p = d[7:0] ^ a[15:8];
      else p = d[7:0] ^ a[7:0];
    end
    return int'(d[15:8]);
  endfunction

  // SRAM with 2-cycle read latency
  always @(posedge clk) begin
    rd1 <= (memReq && !memWe) ? memRd(int'(memAddr)) : 16'h0;
    rd2 <= rd1;
    if (memReq && memWe) wmem[int'(memAddr)] = memWdata;
  end
  assign memRdata = rd2;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  // Per-cycle monitor, sampled 1 ns before the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (updValid && updReady)
        check(memReq && memWe && memAddr == updAddr && memWdata == updData, "R5",
              {memReq, memWe, memAddr}, {2'b11, updAddr});
      if (updValid && !updReady) sawWait++;
      if (resValid) begin
        if (expTag.size() == 0) check(0, "R7 unexpected result", resTag, -1);
        else begin
          int t, h;
          t = expTag.pop_front(); h = expNh.pop_front();
          check(int'(resTag) == t, "R7 tag order", resTag, t);
          check(int'(resNextHop) == h, "R3 next hop", resNextHop, h);
          lastNh = resNextHop;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    inValid = 1; inAddr = a;
    while (!inReady) @(negedge clk);
    expTag.push_back(seq % 8); expNh.push_back(refLookup(a)); seq++;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic drain();
    int g = 0;
    while (expTag.size() > 0 && g < 3000) begin @(negedge clk); g++; end
    repeat (4) @(negedge clk);
    check(expTag.size() == 0, "R8 all results delivered", expTag.size(), 0);
  endtask

  task automatic setCount(input logic [3:0] n);
    @(negedge clk); cfgWe = 1; cfgCount = n;
    @(negedge clk); cfgWe = 0;
  endtask

  // Long lookups back to back; returns how many were taken before inReady fell
  task automatic burst(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (inReady && n < 8) begin
        inValid = 1; inAddr = {8'(n * 29 + 5), 8'(n * 3), 8'h5c, 8'h13};
        expTag.push_back(seq % 8); expNh.push_back(refLookup(inAddr)); seq++; n++;
      end else begin
        inValid = 0; break;
      end
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(inReady == 1, "R1 inReady", inReady, 1);
    check(resValid == 0, "R1 resValid", resValid, 0);
    check(memReq == 0, "R1 memReq", memReq, 0);

    burst(n); check(n == 4, "R1 R2 default count", n, 4); drain();
    setCount(2); burst(n); check(n == 2, "R2 two engines", n, 2); drain();
    setCount(0); burst(n); check(n == 1, "R4 zero clamps to 1", n, 1); drain();
    setCount(15); burst(n); check(n == 4, "R4 large clamps to max", n, 4); drain();
    setCount(3); burst(n); check(n == 3, "R2 three engines", n, 3); drain();

    // R7: long then short lookups finish out of order
    setCount(4);
    send(32'h11223343); send(32'h55667700); send(32'h99aabb01); send(32'hdeadbe00);
    send(32'h01020302); send(32'hc0ffee00);
    drain();

    // R8: reduce count with all engines busy
    send(32'h10203043); send(32'h20304053); send(32'h30405063); send(32'h40506073);
    setCount(1);
    drain();
    burst(n); check(n == 1, "R8 reduced count", n, 1); drain();
    setCount(4);

    // R6/R5: continuous update writes (content unchanged) while lookups run
    sawWait = 0;
    fork
      begin
        for (int i = 0; i < 200; i++) begin
          @(negedge clk); updValid = 1; updAddr = 10'(i); updData = memRd(i);
          #1; while (!updReady) begin @(negedge clk); #1; end
        end
        @(negedge clk); updValid = 0;
      end
      begin
        send(32'h77889903); send(32'h12345603); send(32'habcdef02); send(32'h0f0e0d01);
        send(32'h66554433);
      end
    join
    drain();
    check(sawWait > 0, "R6 reads interleaved with writes", sawWait, 1);

    // R9: update then lookup sees new data
    @(negedge clk); updValid = 1; updAddr = {2'b00, 8'hc3}; updData = 16'h5a00;
    @(negedge clk); updValid = 0;
    send(32'hc3000000);
    drain();
    check(lastNh == 8'h5a, "R9 update visible", lastNh, 8'h5a);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule